// File: doc/BRIEF.md
# Memory Pattern Self-Test Engine

This block is a memory self-test sequencer that sits beside a memory controller. Software fills ten 32-bit pattern words, picks a test type, an address span and a round size, then sets a run bit. The engine issues single-beat requests toward memory, in bursts of eight 64-bit beats, with ascending burst-aligned addresses. It writes the 40-byte pattern so that it repeats without a break, or reads the span back and compares each beat against the same pattern, or does both in rounds.

In write-and-compare mode the round size decides how many bursts are written before that same group is read back and checked. Small rounds catch faults quickly on nearby addresses. A size of zero writes the whole span and then reads the whole span. Completion is shown when the run bit drops. A mismatch sets a sticky failure flag and records the byte address of the first bad beat. A run counts as passed when the run bit has cleared and the failure flag is zero.

Top module: `mbist_top`

## Requirements
- R1: Pattern byte j (0..39) is bits [8*(j%4)+7 : 8*(j%4)] of pattern word j/4, held at register index 6 + j/4. Byte i of a beat is bits [8i+7:8i] of the data. That byte is pattern byte (P+i) mod 40. P is 0 for the first beat of a run and grows by 8 for each beat written or read, carried across bursts and rounds, so the read-back of a round uses the same P values as its writes.
- R2: CTRL (index 0) bits [2:1] select the test type: 0 reads and compares without writing, 1 writes without reading or comparing, and 2 or 3 writes, reads back and compares.
- R3: With CTRL bit 3 set, the span runs from the burst at WIN_LO (index 1) to the burst at WIN_HI (index 2), both inclusive. Address bits [5:0] are ignored, and memory outside the span is not touched.
- R4: With CTRL bit 3 clear, the span runs from SPACE_LO (index 3) to SPACE_HI (index 4), both inclusive, with the same alignment.
- R5: CTRL bits [7:4] = n. In write-and-compare mode with n not zero, n bursts are written and then read back in the same order, round after round, and the final round may be shorter. With n = 0, the whole span is written before any read.
- R6: Writing CTRL with bit 0 set while idle starts a run. CTRL bit 0 reads 1 during the run and is cleared by hardware when the run ends. Register reads return data one cycle after the index is presented, and CTRL reads 0 after reset.
- R7: A compare mismatch sets CTRL bit 8, which stays set until the next start clears it. FAIL_ADDR (index 5) holds the byte address of the first mismatching beat of the run.
- R8: While a run is active, every register write is ignored, including a write that clears bit 0.
- R9: If the span end lies below its start, the run ends at once with CTRL bit 8 set and no memory request issued.
- R10: A request holds its address and direction until it is accepted. Each handshake moves one beat, and addresses are 8-byte aligned. Read data must return in request order, at least one cycle after the request is accepted.
- R11: A write-only run leaves CTRL bit 8 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| mem_req_valid | output | 1 | Beat request valid |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_req_addr | output | AW | Byte address of the beat |
| mem_wdata | output | 64 | Write data of the beat |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, in request order |

## Verification
A wrong pattern phase shows up within one write beat as a word stored in memory that breaks the 40-byte sequence. After a round boundary, a stale phase makes the read-back compare fail, so the failure flag and a false FAIL_ADDR appear as soon as the run bit drops. A wrong round count is seen at the port as the number of write beats issued before the first read. A span or stepping error leaves beats inside the span unwritten or touches beats just outside it. A bad failure latch shows as a wrong FAIL_ADDR or a flag that survives the next start.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_WLO   = 4'd1;
  localparam logic [3:0] A_WHI   = 4'd2;
  localparam logic [3:0] A_SLO   = 4'd3;
  localparam logic [3:0] A_SHI   = 4'd4;
  localparam logic [3:0] A_FADDR = 4'd5;
  localparam logic [3:0] A_PAT0  = 4'd6;

  typedef enum logic [1:0] {
    M_RDONLY = 2'd0,
    M_WRONLY = 2'd1,
    M_WRC    = 2'd2,
    M_WRC2   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_DRAIN, S_END} seq_e;

  typedef struct packed {
    logic       win_en;
    logic [3:0] round_n;
    mode_e      mode;
  } cfg_t;
endpackage

// File: rtl/mbist_regs.sv
module mbist_regs import mbist_pkg::*; #(
  parameter int AW        = 16,
  parameter int BSH       = 6,
  parameter int PAT_WORDS = 10,
  localparam int BW       = AW - BSH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [3:0]                 cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic                       done_p,
  input  logic                       fail_p,
  input  logic [AW-1:0]              fail_addr_i,
  output logic                       run,
  output logic                       start_p,
  output cfg_t                       cfg,
  output logic [BW-1:0]              win_lo,
  output logic [BW-1:0]              win_hi,
  output logic [BW-1:0]              spc_lo,
  output logic [BW-1:0]              spc_hi,
  output logic [PAT_WORDS-1:0][31:0] pat,
  output logic                       status
);
  logic [AW-1:0] fail_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; start_p <= 1'b0; cfg <= '0; status <= 1'b0;
      win_lo <= '0; win_hi <= '0; spc_lo <= '0; spc_hi <= '0;
      pat <= '0; fail_addr_q <= '0;
    end else begin
      start_p <= 1'b0;
      if (done_p) run <= 1'b0;
      if (fail_p) begin
        status <= 1'b1;
        if (!status) fail_addr_q <= fail_addr_i;
      end
      if (cfg_we && !run) begin
        case (cfg_addr)
          A_CTRL: begin
            cfg.mode    <= mode_e'(cfg_wdata[2:1]);
            cfg.win_en  <= cfg_wdata[3];
            cfg.round_n <= cfg_wdata[7:4];
            if (cfg_wdata[0]) begin
              run <= 1'b1; start_p <= 1'b1; status <= 1'b0;
            end
          end
          A_WLO: win_lo <= cfg_wdata[AW-1:BSH];
          A_WHI: win_hi <= cfg_wdata[AW-1:BSH];
          A_SLO: spc_lo <= cfg_wdata[AW-1:BSH];
          A_SHI: spc_hi <= cfg_wdata[AW-1:BSH];
          default: ;
        endcase
        for (int i = 0; i < PAT_WORDS; i++)
          if (cfg_addr == A_PAT0 + 4'(i)) pat[i] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_addr)
        A_CTRL:  cfg_rdata <= {23'd0, status, cfg.round_n, cfg.win_en, cfg.mode, run};
        A_WLO:   cfg_rdata <= 32'({win_lo, {BSH{1'b0}}});
        A_WHI:   cfg_rdata <= 32'({win_hi, {BSH{1'b0}}});
        A_SLO:   cfg_rdata <= 32'({spc_lo, {BSH{1'b0}}});
        A_SHI:   cfg_rdata <= 32'({spc_hi, {BSH{1'b0}}});
        A_FADDR: cfg_rdata <= 32'(fail_addr_q);
        default: cfg_rdata <= '0;
      endcase
      for (int i = 0; i < PAT_WORDS; i++)
        if (cfg_addr == A_PAT0 + 4'(i)) cfg_rdata <= pat[i];
    end
  end
endmodule

// File: rtl/mbist_patsel.sv
module mbist_patsel #(
  parameter int PAT_WORDS = 10,
  parameter int PH_W      = 3
) (
  input  logic [PAT_WORDS-1:0][31:0] pat,
  input  logic [PH_W-1:0]            ph,
  output logic [63:0]                beat
);
  localparam int NBEAT = PAT_WORDS / 2;
  logic [NBEAT-1:0][63:0] tbl;

  for (genvar k = 0; k < NBEAT; k++) begin : g_beat
    assign tbl[k] = {pat[2*k+1], pat[2*k]};
  end

  always_comb begin
    beat = '0;
    for (int k = 0; k < NBEAT; k++)
      if (ph == PH_W'(k)) beat = tbl[k];
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq import mbist_pkg::*; #(
  parameter int AW     = 16,
  parameter int BT_W   = 3,
  parameter int PH_W   = 3,
  parameter int NBEAT  = 5,
  localparam int BW    = AW - BT_W - 3,
  localparam int BW1   = BW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_p,
  input  cfg_t            cfg,
  input  logic [BW-1:0]   lo_b,
  input  logic [BW-1:0]   hi_b,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  input  logic [63:0]     exp_beat,
  output logic [PH_W-1:0] iss_ph,
  output logic [PH_W-1:0] cmp_ph,
  output logic            done_p,
  output logic            fail_p,
  output logic [AW-1:0]   fail_addr
);
  seq_e            st;
  logic [BW-1:0]   rnd_base, last_b, iss_b, cmp_b, rnd_last;
  logic [BT_W-1:0] iss_bt, cmp_bt;
  logic [PH_W-1:0] rnd_ph;
  logic            bad, accept, iss_end, cmp_end, mism;
  logic [3:0]      n_eff;
  logic [BW:0]     cand;

  function automatic logic [PH_W-1:0] ph_inc(input logic [PH_W-1:0] p);
    return (p == PH_W'(NBEAT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    n_eff    = (cfg.mode == M_WRC || cfg.mode == M_WRC2) ? cfg.round_n : 4'd0;
    cand     = {1'b0, rnd_base} + BW1'(n_eff) - 1'b1;
    rnd_last = (n_eff == 4'd0 || cand > {1'b0, last_b}) ? last_b : cand[BW-1:0];
  end

  assign mem_req_valid = (st == S_WR) || (st == S_RD);
  assign mem_req_we    = (st == S_WR);
  assign mem_req_addr  = {iss_b, iss_bt, 3'b000};
  assign accept        = mem_req_valid && mem_req_ready;
  assign iss_end       = (iss_bt == '1) && (iss_b == rnd_last);
  assign cmp_end       = (cmp_bt == '1) && (cmp_b == rnd_last);
  assign mism          = mem_rvalid && (mem_rdata != exp_beat);
  assign done_p        = (st == S_END);
  assign fail_p        = mism || (done_p && bad);
  assign fail_addr     = mism ? {cmp_b, cmp_bt, 3'b000} : {rnd_base, {(BT_W+3){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bad <= 1'b0;
      rnd_base <= '0; last_b <= '0; iss_b <= '0; cmp_b <= '0;
      iss_bt <= '0; cmp_bt <= '0; iss_ph <= '0; cmp_ph <= '0; rnd_ph <= '0;
    end else begin
      if (mem_rvalid) begin
        cmp_ph          <= ph_inc(cmp_ph);
        {cmp_b, cmp_bt} <= {cmp_b, cmp_bt} + 1'b1;
      end
      if (accept) begin
        iss_ph          <= ph_inc(iss_ph);
        {iss_b, iss_bt} <= {iss_b, iss_bt} + 1'b1;
      end
      case (st)
        S_IDLE: if (start_p) begin
          rnd_base <= lo_b; last_b <= hi_b; iss_b <= lo_b; cmp_b <= lo_b;
          iss_bt <= '0; cmp_bt <= '0; iss_ph <= '0; cmp_ph <= '0; rnd_ph <= '0;
          bad <= (hi_b < lo_b);
          if (hi_b < lo_b)              st <= S_END;
          else if (cfg.mode == M_RDONLY) st <= S_RD;
          else                           st <= S_WR;
        end
        S_WR: if (accept && iss_end) begin
          if (cfg.mode == M_WRONLY) st <= S_END;
          else begin
            st <= S_RD; iss_b <= rnd_base; iss_bt <= '0; iss_ph <= rnd_ph;
          end
        end
        S_RD: if (accept && iss_end) st <= S_DRAIN;
        S_DRAIN: if (mem_rvalid && cmp_end) begin
          if (rnd_last == last_b) st <= S_END;
          else begin
            st       <= S_WR;
            rnd_base <= rnd_last + 1'b1;
            rnd_ph   <= ph_inc(cmp_ph);
            iss_b    <= rnd_last + 1'b1;
            iss_bt   <= '0;
            iss_ph   <= ph_inc(cmp_ph);
          end
        end
        S_END: begin st <= S_IDLE; bad <= 1'b0; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_top.sv
module mbist_top import mbist_pkg::*; #(
  parameter int AW          = 16,
  parameter int PAT_WORDS   = 10,
  parameter int BURST_BEATS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata
);
  localparam int BT_W  = $clog2(BURST_BEATS);
  localparam int BSH   = BT_W + 3;
  localparam int BW    = AW - BSH;
  localparam int NBEAT = PAT_WORDS / 2;
  localparam int PH_W  = $clog2(NBEAT);

  logic                       run, start_p, status, done_p, fail_p;
  cfg_t                       cfg;
  logic [BW-1:0]              win_lo, win_hi, spc_lo, spc_hi, lo_b, hi_b;
  logic [PAT_WORDS-1:0][31:0] pat;
  logic [AW-1:0]              fail_addr;
  logic [PH_W-1:0]            iss_ph, cmp_ph;
  logic [63:0]                exp_beat;

  assign lo_b = cfg.win_en ? win_lo : spc_lo;
  assign hi_b = cfg.win_en ? win_hi : spc_hi;

  mbist_regs #(.AW(AW), .BSH(BSH), .PAT_WORDS(PAT_WORDS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .done_p(done_p),
    .fail_p(fail_p), .fail_addr_i(fail_addr), .run(run), .start_p(start_p),
    .cfg(cfg), .win_lo(win_lo), .win_hi(win_hi), .spc_lo(spc_lo),
    .spc_hi(spc_hi), .pat(pat), .status(status)
  );

  mbist_patsel #(.PAT_WORDS(PAT_WORDS), .PH_W(PH_W)) u_wpat (
    .pat(pat), .ph(iss_ph), .beat(mem_wdata)
  );

  mbist_patsel #(.PAT_WORDS(PAT_WORDS), .PH_W(PH_W)) u_epat (
    .pat(pat), .ph(cmp_ph), .beat(exp_beat)
  );

  mbist_seq #(.AW(AW), .BT_W(BT_W), .PH_W(PH_W), .NBEAT(NBEAT)) u_seq (
    .clk(clk), .rst(rst), .start_p(start_p), .cfg(cfg), .lo_b(lo_b),
    .hi_b(hi_b), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .exp_beat(exp_beat),
    .iss_ph(iss_ph), .cmp_ph(cmp_ph), .done_p(done_p), .fail_p(fail_p),
    .fail_addr(fail_addr)
  );
endmodule

// File: rtl/mbist_chk.sv
module mbist_chk import mbist_pkg::*; #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          status,
  input logic          done_p,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input mode_e         mode
);
  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  // R10
  beat_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  // R6
  req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> run);
  // R6
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> $past(done_p));
  // R2
  ro_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mode == M_RDONLY |-> !mem_req_we);
  // R7
  sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
    run && status |=> status);
endmodule

bind mbist_top mbist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .status(status), .done_p(done_p),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mode(cfg.mode)
);

// File: tb/mbist_top_tb.sv
module mbist_top_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [63:0]   mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [63:0]   mem_rdata = '0;

  logic [63:0] mem [0:8191];
  logic [63:0] rq [$];
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] pat [10];
  int wr_beats, rd_beats, first_run, cycles;
  logic got_first;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mbist_top #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // behavioural memory: random ready, in-order responses, latency >= 1 cycle
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[3] | lfsr[7];
    mem_rvalid <= 1'b0;
    if (rq.size() > 0 && lfsr[5]) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= rq.pop_front();
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[15:3]] <= mem_wdata;
        wr_beats <= wr_beats + 1;
      end else begin
        rq.push_back(mem[mem_req_addr[15:3]]);
        rd_beats <= rd_beats + 1;
        if (!got_first) begin first_run <= wr_beats; got_first <= 1'b1; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  function automatic logic [63:0] exp_beat(input int lo, input int addr);
    int ph;
    ph = ((addr - lo) >> 3) % 5;
    return {pat[2*ph+1], pat[2*ph]};
  endfunction

  task automatic run_test(input int lo, input int hi, input bit win, input int mode, input int n);
    logic [31:0] c;
    wr_beats = 0; rd_beats = 0; first_run = -1; got_first = 1'b0;
    wr_reg(win ? 4'd1 : 4'd3, 32'(lo));
    wr_reg(win ? 4'd2 : 4'd4, 32'(hi));
    wr_reg(4'd0, 32'((n << 4) | (int'(win) << 3) | (mode << 1) | 1));
    for (int i = 0; i < 20000; i++) begin
      rd_reg(4'd0, c);
      if (!c[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic region_ok(input int lo, input int hi, input string tag);
    int bad = 0;
    for (int a = lo; a < hi + 64; a += 8)
      if (mem[a >> 3] != exp_beat(lo, a)) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] c;
    rd_reg(4'd0, c);
    check(c == 32'd0, "R6 ctrl after reset", c, 0);
    check(mem_req_valid == 1'b0, "R6 no request after reset", mem_req_valid, 0);
  endtask

  task automatic t_write_only();
    logic [31:0] c;
    run_test(32'h100, 32'h2C0, 1'b1, 1, 0);
    rd_reg(4'd0, c);
    check(c[8] == 1'b0, "R11 write-only status", c[8], 0);
    region_ok(32'h100, 32'h2C0, "R1 R10 pattern continuity in span");
    check(mem[32'hF8 >> 3] == 64'd0, "R3 below span untouched", mem[32'hF8 >> 3], 0);
    check(mem[32'h300 >> 3] == 64'd0, "R3 above span untouched", mem[32'h300 >> 3], 0);
    check(rd_beats == 0, "R2 write-only issues no reads", rd_beats, 0);
    check(wr_beats == 64, "R3 write beat count", wr_beats, 64);
  endtask

  task automatic t_round(input int lo, input int n, input int exp_first, input string tag);
    logic [31:0] c;
    run_test(lo, lo + 32'h1C0, 1'b1, 2, n);
    rd_reg(4'd0, c);
    check(c[8] == 1'b0, "R2 write-read-compare passes", c[8], 0);
    check(first_run == exp_first, tag, first_run, exp_first);
    check(rd_beats == 64 && wr_beats == 64, "R5 every beat written and read", rd_beats, 64);
    region_ok(lo, lo + 32'h1C0, "R1 pattern carried across rounds");
  endtask

  task automatic t_whole_space();
    logic [31:0] c;
    run_test(32'h800, 32'h9C0, 1'b0, 3, 0);
    rd_reg(4'd0, c);
    check(c[8] == 1'b0, "R4 space run passes", c[8], 0);
    check(first_run == 64, "R5 n=0 writes whole span first", first_run, 64);
    check(mem[32'h800 >> 3] == {pat[1], pat[0]}, "R4 space start written", mem[32'h800 >> 3], {pat[1], pat[0]});
  endtask

  task automatic t_read_fault();
    logic [31:0] c, fa;
    run_test(32'hC00, 32'hDC0, 1'b1, 1, 0);
    mem[32'hD00 >> 3] = mem[32'hD00 >> 3] ^ 64'h10;
    mem[32'hC48 >> 3] = mem[32'hC48 >> 3] ^ 64'h1;
    run_test(32'hC00, 32'hDC0, 1'b1, 0, 0);
    rd_reg(4'd0, c);
    rd_reg(4'd5, fa);
    check(c[8] == 1'b1, "R7 mismatch sets status", c[8], 1);
    check(fa == 32'hC48, "R7 first failing address", fa, 32'hC48);
    check(wr_beats == 0 && rd_beats == 64, "R2 read-only issues reads only", wr_beats, 0);
  endtask

  task automatic t_restart_clears();
    logic [31:0] c;
    run_test(32'h100, 32'h1C0, 1'b1, 2, 1);
    rd_reg(4'd0, c);
    check(c[8] == 1'b0, "R7 new start clears status", c[8], 0);
    check(first_run == 8, "R5 n=1 one burst per round", first_run, 8);
  endtask

  task automatic t_bad_range();
    logic [31:0] c;
    run_test(32'h300, 32'h200, 1'b1, 2, 0);
    rd_reg(4'd0, c);
    check(c[8] == 1'b1 && c[0] == 1'b0, "R9 inverted span fails at once", c, 32'h100);
    check(wr_beats + rd_beats == 0, "R9 no requests", wr_beats + rd_beats, 0);
  endtask

  task automatic t_locked();
    logic [31:0] c, p0;
    wr_beats = 0; rd_beats = 0; got_first = 1'b0;
    wr_reg(4'd1, 32'hE00);
    wr_reg(4'd2, 32'hFC0);
    wr_reg(4'd0, 32'h0000_000B);
    wr_reg(4'd6, 32'hDEAD_BEEF);
    wr_reg(4'd0, 32'h0);
    rd_reg(4'd0, c);
    check(c[0] == 1'b1, "R8 clearing run bit ignored", c[0], 1);
    for (int i = 0; i < 20000; i++) begin
      rd_reg(4'd0, c);
      if (!c[0]) break;
    end
    rd_reg(4'd6, p0);
    check(p0 == pat[0], "R8 pattern write ignored", p0, pat[0]);
    region_ok(32'hE00, 32'hFC0, "R8 run used original pattern");
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = '0;
    for (int i = 0; i < 10; i++) pat[i] = 32'h1357_9BDF ^ (32'h0102_0408 * (i + 1)) ^ (i << 28);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int i = 0; i < 10; i++) wr_reg(4'(6 + i), pat[i]);
    t_write_only();
    t_round(32'h400, 2, 16, "R5 n=2 writes two bursts first");
    t_round(32'h000, 3, 24, "R5 n=3 rounds with short last round");
    t_whole_space();
    t_read_fault();
    t_restart_clears();
    t_bad_range();
    t_locked();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end
endmodule